// File: doc/BRIEF.md
# Parallel Register Write Sequencer

This block sits on the host side of a frequency synthesizer that takes its settings over a parallel register bus. The bus has a six-bit address, an eight-bit data byte, an active-low write strobe, a master reset line and an update strobe. The block turns short requests into correctly timed bus cycles. A request carries a kind, an address and a data word of up to 48 bits. The request is either one byte write, a 48-bit tuning word spread over six bytes, or a 12-bit amplitude written to both amplitude channels.

When reset is released, the block first runs its own start-up routine. It gives the synthesizer a master reset pulse, then writes a fixed list of configuration bytes, then issues one final update pulse. Only after this does it take host requests. Each byte written on the bus is followed by its own update pulse, so every register change takes effect at once. The length of each bus phase is a parameter counted in clock cycles: `PH_CYC` for the write phases, `UPD_CYC` for the update phases and `RST_CYC` for the reset intervals.

Top module: `par_reg_seq`

## Requirements
- R1: While `rst_n` is low, `wr_n` is 1, `upd` is 0, `mrst` is 0, `req_ready` is 0 and `busy` is 0.
- R2: After reset is released, `mrst` stays low, then goes high for exactly `RST_CYC` cycles, then returns low. No write strobe and no ready occur before this pulse has ended.
- R3: After the reset pulse, five configuration writes appear in this order as (address, data): (0x1E,0x01), (0x1F,0x02), (0x1D,0x00), (0x20,0x40), (0x19,0x20). They are followed by exactly one extra update pulse with no write attached. Only then can `req_ready` rise.
- R4: In each byte write the address is placed while `wr_n` is high and does not change while `wr_n` is low. `wr_n` stays low for exactly 2·`PH_CYC` cycles, and the data byte is valid when `wr_n` rises.
- R5: Each byte write is followed by exactly one `upd` pulse before the next write begins. The pulse is high for exactly `UPD_CYC` cycles, and `wr_n` stays high throughout it.
- R6: Kind 0 writes `req_data[7:0]` to `req_addr`.
- R7: Kind 1 writes `req_data[47:0]` as six bytes, most significant byte first, to addresses 0x04, 0x05, 0x06, 0x07, 0x08 and 0x09 in that order.
- R8: Kind 2 writes {4'h0, `req_data[11:8]`} to 0x21, then `req_data[7:0]` to 0x22, and then the same two bytes to 0x23 and 0x24. `req_data[47:12]` and `req_addr` have no effect.
- R9: `req_ready` is high only when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `busy` goes high on that edge and stays high until the last update pulse of the job has finished. A request raised during start-up or while busy is held and is not taken early.
- R10: Kind 3 behaves exactly like kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 byte, 1 tuning word, 2 amplitude, 3 byte |
| req_addr | input | 6 | Register address for byte requests |
| req_data | input | 48 | Request payload |
| req_ready | output | 1 | Block idle and able to take a request |
| busy | output | 1 | A host job is in progress |
| bus_addr | output | 6 | Register address bus |
| bus_data | output | 8 | Register data bus |
| wr_n | output | 1 | Active-low write strobe |
| mrst | output | 1 | Master reset to the synthesizer |
| upd | output | 1 | Update strobe |

## Verification
A host request can arrive while the start-up routine is still running. In that case it contends with the configuration list for the bus. The bench raises `req_valid` in the first cycle after reset and keeps it high. It then checks three things: the request is taken only after the extra start-up update pulse, its write is logged after all five configuration writes, and each write is paired with its own update pulse. After that, back-to-back jobs sweep all 64 addresses, several tuning words and several amplitudes. The bench checks the bus log against expected values that it computes itself.

// File: rtl/par_seq_pkg.sv
package par_seq_pkg;

   localparam int SEQ_AW     = 6;
   localparam int SEQ_DW     = 8;
   localparam int WORD_W     = 48;
   localparam int FREQ_BYTES = WORD_W / SEQ_DW;
   localparam int CFG_ITEMS  = 6;
   localparam int IDX_W      = 3;

   localparam logic [SEQ_AW-1:0] FREQ_BASE = 6'h04;
   localparam logic [SEQ_AW-1:0] AMP_A_HI  = 6'h21;
   localparam logic [SEQ_AW-1:0] AMP_A_LO  = 6'h22;
   localparam logic [SEQ_AW-1:0] AMP_B_HI  = 6'h23;
   localparam logic [SEQ_AW-1:0] AMP_B_LO  = 6'h24;

   typedef enum logic [1:0] {
      KIND_BYTE = 2'd0,
      KIND_FREQ = 2'd1,
      KIND_AMP  = 2'd2,
      KIND_ALT  = 2'd3
   } req_kind_e;

   typedef struct packed {
      logic [SEQ_AW-1:0] addr;
      logic [SEQ_DW-1:0] data;
      logic              pulse_only;
   } bus_item_t;

   function automatic bus_item_t cfg_item(input logic [IDX_W-1:0] idx);
      bus_item_t it;
      it.pulse_only = 1'b0;
      case (idx)
         3'd0:    begin it.addr = 6'h1E; it.data = 8'h01; end
         3'd1:    begin it.addr = 6'h1F; it.data = 8'h02; end
         3'd2:    begin it.addr = 6'h1D; it.data = 8'h00; end
         3'd3:    begin it.addr = 6'h20; it.data = 8'h40; end
         3'd4:    begin it.addr = 6'h19; it.data = 8'h20; end
         default: begin it.addr = '0; it.data = '0; it.pulse_only = 1'b1; end
      endcase
      return it;
   endfunction

   function automatic bus_item_t job_item(input req_kind_e kind,
                                          input logic [SEQ_AW-1:0] base,
                                          input logic [WORD_W-1:0] word,
                                          input logic [IDX_W-1:0] idx);
      bus_item_t it;
      it.pulse_only = 1'b0;
      case (kind)
         KIND_FREQ: begin
            it.addr = FREQ_BASE + SEQ_AW'(idx);
            it.data = SEQ_DW'(word >> (SEQ_DW * (FREQ_BYTES - 1 - int'(idx))));
         end
         KIND_AMP: begin
            case (idx[1:0])
               2'd0:    it.addr = AMP_A_HI;
               2'd1:    it.addr = AMP_A_LO;
               2'd2:    it.addr = AMP_B_HI;
               default: it.addr = AMP_B_LO;
            endcase
            it.data = idx[0] ? word[7:0] : {4'h0, word[11:8]};
         end
         default: begin
            it.addr = base;
            it.data = word[SEQ_DW-1:0];
         end
      endcase
      return it;
   endfunction

   function automatic logic [IDX_W-1:0] job_last(input req_kind_e kind);
      case (kind)
         KIND_FREQ: return IDX_W'(FREQ_BYTES - 1);
         KIND_AMP:  return 3'd3;
         default:   return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/par_wr_engine.sv
module par_wr_engine
   import par_seq_pkg::*;
#(
   parameter int PH_CYC    = 2,
   parameter int UPD_CYC   = 3,
   parameter bit DATA_LATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  bus_item_t         item,
   output logic              done,
   output logic [SEQ_AW-1:0] bus_addr,
   output logic [SEQ_DW-1:0] bus_data,
   output logic              wr_n,
   output logic              upd
);

   localparam int MAXC  = (PH_CYC > UPD_CYC) ? PH_CYC : UPD_CYC;
   localparam int CNT_W = $clog2(MAXC + 1) + 1;

   typedef enum logic [2:0] {
      E_IDLE, E_ADDR, E_LOW, E_DATA, E_HIGH, E_U0, E_U1, E_U2
   } eng_st_e;

   eng_st_e           st;
   logic [CNT_W-1:0]  cnt;
   logic [SEQ_DW-1:0] hold;
   logic              last;

   assign last = (cnt == '0);
   assign wr_n = !((st == E_LOW) || (st == E_DATA));
   assign upd  = (st == E_U1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= E_IDLE;
         cnt      <= '0;
         hold     <= '0;
         bus_addr <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            E_IDLE: if (start) begin
               hold <= item.data;
               if (item.pulse_only) begin
                  st  <= E_U0;
                  cnt <= CNT_W'(UPD_CYC - 1);
               end else begin
                  st       <= E_ADDR;
                  bus_addr <= item.addr;
                  cnt      <= CNT_W'(PH_CYC - 1);
               end
            end
            E_ADDR: if (last) begin st <= E_LOW;  cnt <= CNT_W'(PH_CYC - 1); end
                    else cnt <= cnt - 1'b1;
            E_LOW:  if (last) begin st <= E_DATA; cnt <= CNT_W'(PH_CYC - 1); end
                    else cnt <= cnt - 1'b1;
            E_DATA: if (last) begin st <= E_HIGH; cnt <= CNT_W'(PH_CYC - 1); end
                    else cnt <= cnt - 1'b1;
            E_HIGH: if (last) begin st <= E_U0;   cnt <= CNT_W'(UPD_CYC - 1); end
                    else cnt <= cnt - 1'b1;
            E_U0:   if (last) begin st <= E_U1;   cnt <= CNT_W'(UPD_CYC - 1); end
                    else cnt <= cnt - 1'b1;
            E_U1:   if (last) begin st <= E_U2;   cnt <= CNT_W'(UPD_CYC - 1); end
                    else cnt <= cnt - 1'b1;
            E_U2:   if (last) begin st <= E_IDLE; done <= 1'b1; end
                    else cnt <= cnt - 1'b1;
            default: st <= E_IDLE;
         endcase
      end
   end

   // The data bus is driven either after the strobe has fallen or together with the address.
   generate
      if (DATA_LATE) begin : g_data_late
         always_ff @(posedge clk) begin
            if (!rst_n)                    bus_data <= '0;
            else if (st == E_LOW && last)  bus_data <= hold;
         end
      end else begin : g_data_early
         always_ff @(posedge clk) begin
            if (!rst_n)                                     bus_data <= '0;
            else if (st == E_IDLE && start && !item.pulse_only) bus_data <= item.data;
         end
      end
   endgenerate

   // R4: the address must not move while the strobe is low
   assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && $past(!wr_n)) |-> $stable(bus_addr));

   // R5: the update pulse and the write strobe never overlap
   assert_upd_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> wr_n);

endmodule

// File: rtl/par_seq_ctrl.sv
module par_seq_ctrl
   import par_seq_pkg::*;
#(
   parameter int PH_CYC  = 2,
   parameter int RST_CYC = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [SEQ_AW-1:0] req_addr,
   input  logic [WORD_W-1:0] req_data,
   output logic              req_ready,
   output logic              busy,
   output logic              mrst,
   output logic              eng_start,
   output bus_item_t         eng_item,
   input  logic              eng_done
);

   localparam int RMAX  = (RST_CYC > PH_CYC) ? RST_CYC : PH_CYC;
   localparam int RCNT_W = $clog2(RMAX + 1) + 1;

   typedef enum logic [2:0] {
      S_R0, S_R1, S_R2, S_GO, S_WAIT, S_IDLE
   } seq_st_e;

   seq_st_e           st;
   logic [RCNT_W-1:0] rcnt;
   logic [IDX_W-1:0]  idx;
   logic              in_init;
   req_kind_e         kind_q;
   logic [SEQ_AW-1:0] addr_q;
   logic [WORD_W-1:0] word_q;
   logic [IDX_W-1:0]  last_idx;

   assign req_ready = (st == S_IDLE);
   assign mrst      = (st == S_R1);
   assign eng_start = (st == S_GO);
   assign eng_item  = in_init ? cfg_item(idx) : job_item(kind_q, addr_q, word_q, idx);
   assign last_idx  = in_init ? IDX_W'(CFG_ITEMS - 1) : job_last(kind_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_R0;
         rcnt    <= RCNT_W'(RST_CYC - 1);
         idx     <= '0;
         in_init <= 1'b1;
         busy    <= 1'b0;
         kind_q  <= KIND_BYTE;
         addr_q  <= '0;
         word_q  <= '0;
      end else begin
         case (st)
            S_R0: if (rcnt == '0) begin st <= S_R1; rcnt <= RCNT_W'(RST_CYC - 1); end
                  else rcnt <= rcnt - 1'b1;
            S_R1: if (rcnt == '0) begin st <= S_R2; rcnt <= RCNT_W'(PH_CYC - 1); end
                  else rcnt <= rcnt - 1'b1;
            S_R2: if (rcnt == '0) begin st <= S_GO; idx <= '0; end
                  else rcnt <= rcnt - 1'b1;
            S_GO: st <= S_WAIT;
            S_WAIT: if (eng_done) begin
               if (idx == last_idx) begin
                  st      <= S_IDLE;
                  busy    <= 1'b0;
                  in_init <= 1'b0;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= S_GO;
               end
            end
            S_IDLE: if (req_valid) begin
               kind_q <= req_kind_e'(req_kind);
               addr_q <= req_addr;
               word_q <= req_data;
               idx    <= '0;
               busy   <= 1'b1;
               st     <= S_GO;
            end
            default: st <= S_R0;
         endcase
      end
   end

   // R9: a running job keeps the request port closed
   assert_busy_closes_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

   // R9: taking a request raises busy on the next cycle
   assert_take_sets_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);

endmodule

// File: rtl/par_reg_seq.sv
module par_reg_seq
   import par_seq_pkg::*;
#(
   parameter int PH_CYC    = 2,
   parameter int UPD_CYC   = 3,
   parameter int RST_CYC   = 20,
   parameter bit DATA_LATE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [1:0]  req_kind,
   input  logic [5:0]  req_addr,
   input  logic [47:0] req_data,
   output logic        req_ready,
   output logic        busy,
   output logic [5:0]  bus_addr,
   output logic [7:0]  bus_data,
   output logic        wr_n,
   output logic        mrst,
   output logic        upd
);

   initial begin
      assert (PH_CYC >= 1)  else $error("PH_CYC must be at least 1");
      assert (UPD_CYC >= 1) else $error("UPD_CYC must be at least 1");
      assert (RST_CYC >= 1) else $error("RST_CYC must be at least 1");
      assert (SEQ_AW == 6 && SEQ_DW == 8) else $error("bus widths must be 6 and 8");
      assert (FREQ_BYTES * SEQ_DW == WORD_W) else $error("word must split into whole bytes");
   end

   logic      eng_start;
   logic      eng_done;
   bus_item_t eng_item;

   par_seq_ctrl #(.PH_CYC(PH_CYC), .RST_CYC(RST_CYC)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .req_ready (req_ready),
      .busy      (busy),
      .mrst      (mrst),
      .eng_start (eng_start),
      .eng_item  (eng_item),
      .eng_done  (eng_done)
   );

   par_wr_engine #(.PH_CYC(PH_CYC), .UPD_CYC(UPD_CYC), .DATA_LATE(DATA_LATE)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (eng_start),
      .item     (eng_item),
      .done     (eng_done),
      .bus_addr (bus_addr),
      .bus_data (bus_data),
      .wr_n     (wr_n),
      .upd      (upd)
   );

   // R2: while the master reset is high the bus stays quiet
   assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mrst |-> (wr_n && !upd && !req_ready));

endmodule

// File: tb/tb_par_reg_seq.sv
module tb_par_reg_seq;

   localparam int PH  = 2;
   localparam int UPC = 3;
   localparam int RSC = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [5:0]  req_addr = 6'd0;
   logic [47:0] req_data = 48'd0;
   logic        req_ready, busy, wr_n, mrst, upd;
   logic [5:0]  bus_addr;
   logic [7:0]  bus_data;

   par_reg_seq #(.PH_CYC(PH), .UPD_CYC(UPC), .RST_CYC(RSC), .DATA_LATE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready), .busy(busy),
      .bus_addr(bus_addr), .bus_data(bus_data), .wr_n(wr_n), .mrst(mrst), .upd(upd)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;

   logic [5:0] exp_a [0:255];
   logic [7:0] exp_d [0:255];
   string      exp_r [0:255];
   int         n_exp = 0;
   logic [5:0] act_a [0:255];
   logic [7:0] act_d [0:255];
   int         n_act = 0;

   int  extras = 0;
   bit  pending = 0;
   bit  mrst_done = 0;
   int  low_cnt = 0, hi_cnt = 0, rst_hi = 0, mrst_rises = 0;
   logic [5:0] addr_at_fall = '0;
   logic prev_wr = 1'b1, prev_upd = 1'b0, prev_mrst = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic expect_wr(input logic [5:0] a, input logic [7:0] d, input string r);
      exp_a[n_exp] = a; exp_d[n_exp] = d; exp_r[n_exp] = r; n_exp++;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // bus monitor, sampled on the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         check(wr_n == 1'b1 && upd == 1'b0 && mrst == 1'b0 && req_ready == 1'b0 && busy == 1'b0,
               "R1", "reset outputs", {wr_n, upd, mrst, req_ready, busy}, 5'b10000);
      end else begin
         if (mrst) rst_hi++;
         if (!prev_mrst && mrst) mrst_rises++;
         if (prev_mrst && !mrst) begin
            check(rst_hi == RSC, "R2", "master reset width", rst_hi, RSC);
            mrst_done = 1;
         end
         if (req_ready && extras == 0)
            check(0, "R3", "ready before start-up end", 1, 0);
         if (req_ready && busy)
            check(0, "R9", "ready while busy", 1, 0);
         if (!wr_n) low_cnt++;
         if (prev_wr && !wr_n) addr_at_fall = bus_addr;
         if (!prev_wr && wr_n) begin
            check(mrst_done, "R2", "write before reset pulse end", 0, 1);
            check(low_cnt == 2 * PH, "R4", "strobe low width", low_cnt, 2 * PH);
            check(bus_addr == addr_at_fall, "R4", "address moved", bus_addr, addr_at_fall);
            if (pending) check(0, "R5", "write without update pulse", n_act, n_act + 1);
            pending = 1;
            low_cnt = 0;
            if (n_act < 256) begin act_a[n_act] = bus_addr; act_d[n_act] = bus_data; end
            n_act++;
         end
         if (upd) begin
            hi_cnt++;
            if (!wr_n) check(0, "R5", "update during strobe", 0, 1);
         end
         if (!prev_upd && upd) begin
            if (pending) pending = 0;
            else begin
               extras++;
               check(extras == 1 && n_act == 5, "R3", "extra pulse placement", n_act, 5);
            end
         end
         if (prev_upd && !upd) begin
            check(hi_cnt == UPC, "R5", "update width", hi_cnt, UPC);
            hi_cnt = 0;
         end
      end
      prev_wr = wr_n; prev_upd = upd; prev_mrst = mrst;
   end

   task automatic send(input logic [1:0] k, input logic [5:0] a, input logic [47:0] d);
      @(negedge clk);
      req_kind = k; req_addr = a; req_data = d; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1, "R9", "busy after take", busy, 1);
      check(extras == 1, "R9", "taken before start-up end", extras, 1);
      while (busy) @(negedge clk);
      check(!pending, "R5", "job ended without update", pending, 0);
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            check(0, "R9", "watchdog expired", cyc, 150000);
            finish_run();
         end
      end
   end

   initial begin
      logic [47:0] words [0:4];
      logic [47:0] amps  [0:4];
      words[0] = 48'h0; words[1] = 48'hFFFF_FFFF_FFFF; words[2] = 48'h1234_5678_9ABC;
      words[3] = 48'h8000_0000_0001; words[4] = 48'h00A5_5A00_FF01;
      amps[0] = 48'h0; amps[1] = 48'hFFF; amps[2] = 48'h800;
      amps[3] = 48'hDEAD_BEEF_F0A5; amps[4] = 48'h0_0000_037E;

      // R3: start-up configuration list
      expect_wr(6'h1E, 8'h01, "R3"); expect_wr(6'h1F, 8'h02, "R3");
      expect_wr(6'h1D, 8'h00, "R3"); expect_wr(6'h20, 8'h40, "R3");
      expect_wr(6'h19, 8'h20, "R3");

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R9: request raised at once, must wait for start-up
      expect_wr(6'h3F, 8'hA5, "R9");
      send(2'd0, 6'h3F, 48'hFFFF_FFFF_FFA5);

      // R6 / R10: every address, byte kinds
      for (int i = 0; i < 64; i++) begin
         logic [7:0] dv;
         dv = 8'((i * 37 + 5) & 8'hFF);
         if (i % 8 == 0) begin
            expect_wr(6'(i), dv, "R10");
            send(2'd3, 6'(i), {40'hABCDE12345, dv});
         end else begin
            expect_wr(6'(i), dv, "R6");
            send(2'd0, 6'(i), {40'h0, dv});
         end
      end

      // R7: tuning words
      for (int w = 0; w < 5; w++) begin
         for (int b = 0; b < 6; b++)
            expect_wr(6'(4 + b), 8'(words[w] >> (8 * (5 - b))), "R7");
         send(2'd1, 6'h2A, words[w]);
      end

      // R8: amplitudes, upper bits and address ignored
      for (int m = 0; m < 5; m++) begin
         expect_wr(6'h21, {4'h0, amps[m][11:8]}, "R8");
         expect_wr(6'h22, amps[m][7:0], "R8");
         expect_wr(6'h23, {4'h0, amps[m][11:8]}, "R8");
         expect_wr(6'h24, amps[m][7:0], "R8");
         send(2'd2, 6'h15, amps[m]);
      end

      repeat (10) @(negedge clk);
      check(n_act == n_exp, "R6", "write count", n_act, n_exp);
      check(extras == 1, "R3", "extra pulse count", extras, 1);
      check(mrst_rises == 1, "R2", "reset pulse count", mrst_rises, 1);
      for (int i = 0; i < n_exp && i < n_act; i++) begin
         check(act_a[i] == exp_a[i], exp_r[i], $sformatf("address of write %0d", i),
               act_a[i], exp_a[i]);
         check(act_d[i] == exp_d[i], exp_r[i], $sformatf("data of write %0d", i),
               act_d[i], exp_d[i]);
      end
      finish_run();
   end

endmodule